// File: doc/BRIEF.md
# Edge-Triggered Wake-Up Pending Controller

This block watches a set of asynchronous wake-up inputs (sixteen by default) and records, for each one, whether a qualifying edge has arrived. Software chooses per line whether the rising or the falling edge counts. A qualifying edge latches a sticky pending flag, which stays set until software writes a 0 to it. Software may also write a 1 to a pending flag to raise a software wake or interrupt request.

Access goes through a small byte-wide register port. The lines are grouped in bytes; each byte has a polarity register and a pending register. A single registered request output is high while any pending flag is set. Masking, priority and power sequencing are handled elsewhere. The reset input is asserted asynchronously and is expected to be released in step with the clock.

Top module: `wkup_edge_ctrl`

## Requirements
- R1: After reset all four registers read 00h and `wake_req` is low.
- R2: With polarity bit 1, a rising edge on a line sets its pending flag; the flag reads 1 after the third rising clock edge that follows the input change (two synchroniser flops plus the flag).
- R3: With polarity bit 0, a falling edge on a line sets its pending flag with the same latency as R2.
- R4: An edge of the opposite direction to the selected polarity leaves the pending flag clear.
- R5: A set pending flag stays set until software writes 0 to that bit; writing 0 clears it.
- R6: Writing 1 to a pending bit sets that flag with no edge on the line.
- R7: A qualifying edge whose detection cycle coincides with a write to the polarity register covering its line is dropped; lines in the other byte are unaffected.
- R8: Polarity bits read back exactly as written and are never altered by hardware.
- R9: When a qualifying edge and a software write of 0 meet the same pending bit in the same cycle, the flag ends up set.
- R10: `wake_req` is high exactly when at least one pending flag is set, lagging the flags by one clock.
- R11: Changing a polarity bit while the line is steady does not set its pending flag.
- R12: Register map: address 0 = polarity lines 15..8, 1 = polarity lines 7..0, 2 = pending lines 15..8, 3 = pending lines 7..0; line n sits at bit n mod 8; reads are combinational from `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_in | input | 16 | Asynchronous wake-up lines |
| wr_en | input | 1 | One-cycle register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| wake_req | output | 1 | Registered OR of all pending flags |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions: an edge whose detection cycle lands exactly on a polarity write (R7), or on a pending clear (R9). The bench changes an input on a falling clock edge, counts two rising edges through the synchroniser, and then asserts the write strobe for the third rising edge. In the R7 case, a second line in the other byte changes at the same moment. That line must still latch, which shows the suppression is per byte.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/wkup_edge.sv
module wkup_edge #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] blk,
  output logic [W-1:0] evt
);
  logic [W-1:0] hist_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  // only the input history decides an edge; polarity just selects which one
  always_comb begin
    rise = lvl & ~hist_q;
    fall = ~lvl & hist_q;
    evt  = ((rise & pol) | (fall & ~pol)) & ~blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= lvl;
  end
endmodule

// File: rtl/wkup_bank.sv
module wkup_bank #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_we,
  input  logic          pend_we,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] evt,
  output logic [BW-1:0] trig_q,
  output logic [BW-1:0] pend_q
);
  logic [BW-1:0] trig_d;
  logic [BW-1:0] pend_d;
  logic          trig_en;
  logic          pend_en;

  always_comb begin
    trig_en = trig_we;
    trig_d  = wdata;
    // hardware set is OR-ed last so a clear cannot hide an event
    pend_d  = (pend_we ? wdata : pend_q) | evt;
    pend_en = pend_we | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trig_q <= '0;
    else if (trig_en) trig_q <= trig_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/wkup_edge_ctrl.sv
module wkup_edge_ctrl
  import wkup_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 2,
  localparam int unsigned LINES  = NUM_BYTES * BYTE_W,
  localparam int unsigned SEL_W  = $clog2(NUM_BYTES),
  localparam int unsigned ADDR_W = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  wake_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              wake_req
);
  logic [LINES-1:0]     lvl_s;
  logic [LINES-1:0]     trig_all;
  logic [LINES-1:0]     pend_all;
  logic [LINES-1:0]     evt_all;
  logic [LINES-1:0]     blk_all;
  logic [NUM_BYTES-1:0] trig_we;
  logic [NUM_BYTES-1:0] pend_we;
  logic                 any_d;
  logic                 wake_q;

  // address: top bit picks pending, low bits pick byte with highest byte at 0
  logic [SEL_W-1:0] sel;
  logic             is_pend;
  int unsigned      rd_byte;

  assign sel     = addr[SEL_W-1:0];
  assign is_pend = addr[ADDR_W-1];

  wkup_sync #(.W(LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(wake_in), .dout(lvl_s)
  );

  wkup_edge #(.W(LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .pol(trig_all),
    .blk(blk_all), .evt(evt_all)
  );

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    localparam int unsigned SEL_V = NUM_BYTES - 1 - b;
    always_comb begin
      trig_we[b] = wr_en && !is_pend && (sel == SEL_W'(SEL_V));
      pend_we[b] = wr_en &&  is_pend && (sel == SEL_W'(SEL_V));
      blk_all[b*BYTE_W +: BYTE_W] = {BYTE_W{trig_we[b]}};
    end

    wkup_bank #(.BW(BYTE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_we(trig_we[b]),
      .pend_we(pend_we[b]),
      .wdata  (wdata),
      .evt    (evt_all[b*BYTE_W +: BYTE_W]),
      .trig_q (trig_all[b*BYTE_W +: BYTE_W]),
      .pend_q (pend_all[b*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    rd_byte = NUM_BYTES - 1 - 32'(sel);
    rdata   = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (rd_byte == b) begin
        rdata = is_pend ? pend_all[b*BYTE_W +: BYTE_W]
                        : trig_all[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign any_d = |pend_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= any_d;
  end

  assign wake_req = wake_q;
endmodule

// File: rtl/wkup_edge_chk.sv
module wkup_edge_chk #(
  parameter int unsigned NUM_BYTES = 2,
  parameter int unsigned BW        = 8,
  localparam int unsigned LINES  = NUM_BYTES * BW,
  localparam int unsigned SEL_W  = $clog2(NUM_BYTES),
  localparam int unsigned ADDR_W = SEL_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [LINES-1:0]  trig_all,
  input logic [LINES-1:0]  pend_all,
  input logic [LINES-1:0]  evt_all,
  input logic              wake_req
);
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_TRIG = {1'b0, SEL_W'(NUM_BYTES - 1 - b)};
    localparam logic [ADDR_W-1:0] A_PEND = {1'b1, SEL_W'(NUM_BYTES - 1 - b)};

    // R5: no pending bit drops without a write to its pending register
    assert_no_silent_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_PEND) |=>
        (($past(pend_all[b*BW +: BW]) & ~pend_all[b*BW +: BW]) == '0));

    // R8: polarity byte only changes on its own write
    assert_trig_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_TRIG) |=> $stable(trig_all[b*BW +: BW]));

    // R7: a polarity write to this byte leaves its pending byte untouched
    assert_trig_write_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_TRIG) |=> $stable(pend_all[b*BW +: BW]));

    // R9: a detected event survives a simultaneous pending write
    assert_hw_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_PEND) |=>
        ((pend_all[b*BW +: BW] & $past(evt_all[b*BW +: BW])) == $past(evt_all[b*BW +: BW])));
  end

  // R10: request follows the pending set one cycle later
  assert_req_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all != '0) |=> wake_req);

  assert_req_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all == '0) |=> !wake_req);
endmodule

bind wkup_edge_ctrl wkup_edge_chk #(.NUM_BYTES(NUM_BYTES), .BW(wkup_pkg::BYTE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .trig_all(trig_all),
  .pend_all(pend_all),
  .evt_all (evt_all),
  .wake_req(wake_req)
);

// File: tb/sim_wkup_edge_ctrl.sv
`timescale 1ns/1ps
module sim_wkup_edge_ctrl;
  logic        clk;
  logic        rst_n;
  logic [15:0] wake_in;
  logic        wr_en;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        wake_req;

  int checks;
  int failures;

  wkup_edge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wake_req(wake_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: {expect_set, rising_edge, polarity, line[3:0]}
  localparam logic [6:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b1, 4'd12},
    {1'b1, 1'b1, 1'b1, 4'd5},
    {1'b1, 1'b0, 1'b0, 4'd0},
    {1'b1, 1'b0, 1'b0, 4'd15},
    {1'b0, 1'b0, 1'b1, 4'd7},
    {1'b0, 1'b1, 1'b0, 4'd10},
    {1'b1, 1'b1, 1'b1, 4'd1},
    {1'b1, 1'b0, 1'b0, 4'd8}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] hi;
    logic [7:0] lo;
    checks = 0; failures = 0;
    wake_in = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 8'h00, "R1 reset reg", d, 0);
    end
    check(wake_req == 1'b0, "R1 reset wake_req", wake_req, 0);

    // R12 / R8 register map and readback
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h3C);
    rd(2'd0, d); check(d == 8'hA5, "R12 R8 trig hi readback", d, 8'hA5);
    rd(2'd1, d); check(d == 8'h3C, "R12 R8 trig lo readback", d, 8'h3C);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);

    // table: R2 R3 R4
    for (int v = 0; v < 8; v++) begin
      int   ln;
      logic pol, rise, ex;
      ln = int'(VEC[v][3:0]); pol = VEC[v][4]; rise = VEC[v][5]; ex = VEC[v][6];
      @(negedge clk);
      wake_in = '0;
      wake_in[ln] = ~rise;
      idle(4);
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h00);
      wr(2'd0, (ln >= 8) ? (8'(pol) << (ln - 8)) : 8'h00);
      wr(2'd1, (ln <  8) ? (8'(pol) << ln) : 8'h00);
      @(negedge clk);
      wake_in[ln] = rise;
      idle(3);
      rd(2'd2, hi);
      rd(2'd3, lo);
      begin
        logic [15:0] got, exp;
        got = {hi, lo};
        exp = ex ? (16'h1 << ln) : 16'h0;
        check(got == exp, ex ? (pol ? "R2 rising sets" : "R3 falling sets") : "R4 opposite edge ignored",
              int'(got), int'(exp));
      end
    end

    // R5 sticky then cleared by writing 0; R10 request
    @(negedge clk) wake_in = '0;
    idle(4);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    wr(2'd1, 8'h10);
    @(negedge clk) wake_in[4] = 1'b1;
    idle(3);
    @(negedge clk) wake_in[4] = 1'b0;
    idle(6);
    rd(2'd3, d); check(d == 8'h10, "R5 flag sticky", d, 8'h10);
    check(wake_req == 1'b1, "R10 request while pending", wake_req, 1);
    wr(2'd3, 8'h00);
    rd(2'd3, d); check(d == 8'h00, "R5 write 0 clears", d, 0);
    @(negedge clk);
    check(wake_req == 1'b0, "R10 request drops", wake_req, 0);

    // R6 software set; R10 one-cycle lag
    wr(2'd2, 8'h40);
    check(wake_req == 1'b0, "R10 lag one cycle", wake_req, 0);
    @(negedge clk);
    check(wake_req == 1'b1, "R10 request rises", wake_req, 1);
    rd(2'd2, d); check(d == 8'h40, "R6 software set", d, 8'h40);
    wr(2'd2, 8'h00);

    // R11 polarity change with steady high line
    @(negedge clk) wake_in = 16'h0202;
    idle(4);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    wr(2'd0, 8'h02); wr(2'd1, 8'h02);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    idle(4);
    rd(2'd2, hi); rd(2'd3, lo);
    check({hi, lo} == 16'h0, "R11 polarity change no event", int'({hi, lo}), 0);

    // R7 trigger write collides with edge on line 9; line 2 in other byte still latches
    @(negedge clk) wake_in = '0;
    idle(4);
    wr(2'd0, 8'h02); wr(2'd1, 8'h04);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    @(negedge clk) wake_in = 16'h0204;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 8'h02;
    @(negedge clk); wr_en = 1'b0;
    idle(2);
    rd(2'd2, hi); check(hi == 8'h00, "R7 edge dropped on trig write", hi, 0);
    rd(2'd3, lo); check(lo == 8'h04, "R7 other byte unaffected", lo, 8'h04);
    rd(2'd0, d);  check(d == 8'h02, "R8 trig unchanged by hardware", d, 8'h02);

    // R9 hardware set beats software clear
    @(negedge clk) wake_in = '0;
    idle(4);
    wr(2'd1, 8'h08);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h01);
    @(negedge clk) wake_in[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd3; wdata = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd3, d); check(d == 8'h08, "R9 hw set wins over clear", d, 8'h08);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule